// File: doc/BRIEF.md
# Stream identifier span filter

This block screens every incoming transaction by its stream identifier and reports, for each event counter, whether that transaction qualifies for counting. Each counter owns a filter made of an enable, a span flag and a stream-ID pattern, written through a simple indexed write port. A disabled filter lets everything through. An exact filter needs the whole identifier to equal the pattern. A span filter compares only the upper bits. The pattern itself sets how many low bits are ignored: its lowest zero bit and every one bit below that zero become don't-care.

A mode strap selects between per-counter filtering and a global mode. In global mode, the filter held by counter 0 judges every counter, and the settings of the other counters are left unused. The qualify vector is registered. It appears one clock after the event strobe, and it stays zero in any cycle that follows a cycle with no strobe. Selecting the event type and counting are done by neighbouring logic.

Top module: `sid_span_filter`

## Requirements
- R1: While reset is asserted, `qual` is all zeros. After reset every filter is disabled with span 0 and pattern 0, so an event qualifies on every counter.
- R2: With a filter's enable at 0, its counter qualifies for any stream ID.
- R3: With enable 1 and span 0, a counter qualifies only when `evt_sid` equals the pattern in all SID_W bits.
- R4: With enable 1 and span 1, the ignored bits are the lowest zero bit of the pattern and all bits below it, which is the mask pattern XOR (pattern + 1). The counter qualifies when every bit outside that mask equals the pattern. For example, pattern 0x0043 accepts 0x0040 to 0x0047, and pattern 0x0042 accepts 0x0042 and 0x0043.
- R5: A span filter whose pattern is all ones ignores every bit and qualifies any stream ID.
- R6: With `global_mode` at 1, every bit of `qual` follows the filter of counter 0. The filters of the other counters have no effect.
- R7: `qual` is registered. The result for an event strobed at a clock edge is visible after that edge and stays until the next edge. After an edge with `evt_valid` low, `qual` is all zeros. Bit i belongs to counter i.
- R8: A write with `cfg_we` at 1 loads enable, span and pattern into the counter selected by `cfg_idx`. An index of NUM_CTR or higher changes nothing. An event strobed at the same edge as a write still uses the old settings.
- R9: With `global_mode` at 0, each counter applies its own filter independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| global_mode | input | 1 | Strap: 1 makes counter 0's filter judge all counters |
| cfg_we | input | 1 | Filter write strobe |
| cfg_idx | input | IDX_W | Counter whose filter is written |
| cfg_en | input | 1 | Filter enable to write |
| cfg_span | input | 1 | Span flag to write |
| cfg_pattern | input | SID_W | Stream-ID pattern to write |
| evt_valid | input | 1 | Event strobe |
| evt_sid | input | SID_W | Stream ID of the event |
| qual | output | NUM_CTR | Per-counter qualify result, one clock after the strobe |

## Verification
The bench builds the block with NUM_CTR=3 and SID_W=16. The counter count is not a power of two, so index 3 can be encoded on `cfg_idx` but points at no counter, and the ignored-write case becomes reachable. The narrow identifier lets the all-ones pattern wrap to a full ignore mask with short constants. Three counters are enough to show exact, span and disabled filters side by side in one qualify vector, under both states of the global strap.

// File: rtl/sid_span_filter.sv
module sid_span_filter #(
  parameter int NUM_CTR = 4,
  parameter int SID_W   = 32,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               global_mode,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_en,
  input  logic               cfg_span,
  input  logic [SID_W-1:0]   cfg_pattern,
  input  logic               evt_valid,
  input  logic [SID_W-1:0]   evt_sid,
  output logic [NUM_CTR-1:0] qual
);

  logic [NUM_CTR-1:0] en_q;
  logic [NUM_CTR-1:0] span_q;
  logic [SID_W-1:0]   pat_q [NUM_CTR];
  logic [NUM_CTR-1:0] hit;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CTR; i++) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        span_q[i] <= 1'b0;
        pat_q[i]  <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
        en_q[i]   <= cfg_en;
        span_q[i] <= cfg_span;
        pat_q[i]  <= cfg_pattern;
      end
    end
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    localparam int SRC = 0;
    logic             f_en;
    logic             f_span;
    logic [SID_W-1:0] f_pat;
    logic [SID_W-1:0] f_mask;

    assign f_en   = global_mode ? en_q[SRC]   : en_q[g];
    assign f_span = global_mode ? span_q[SRC] : span_q[g];
    assign f_pat  = global_mode ? pat_q[SRC]  : pat_q[g];
    assign f_mask = f_span ? (f_pat ^ (f_pat + SID_W'(1))) : '0;
    assign hit[g] = !f_en || (((evt_sid ^ f_pat) & ~f_mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) qual <= '0;
    else        qual <= evt_valid ? hit : '0;
  end

endmodule

module sid_span_filter_chk #(
  parameter int NUM_CTR = 4,
  parameter int SID_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               global_mode,
  input logic               evt_valid,
  input logic [SID_W-1:0]   evt_sid,
  input logic               en0,
  input logic               span0,
  input logic [SID_W-1:0]   pat0,
  input logic [NUM_CTR-1:0] qual
);

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> (qual == '0));

  a_r6_global_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (global_mode && evt_valid) |=> ($countones(qual) == 0 || $countones(qual) == NUM_CTR));

  a_r2_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !en0) |=> qual[0]);

  a_r3_exact_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && en0 && !span0 && evt_sid == pat0) |=> qual[0]);

  a_r5_all_ones_span: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && en0 && span0 && (&pat0)) |=> qual[0]);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (qual == '0));

endmodule

bind sid_span_filter sid_span_filter_chk #(.NUM_CTR(NUM_CTR), .SID_W(SID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .global_mode(global_mode), .evt_valid(evt_valid),
  .evt_sid(evt_sid), .en0(en_q[0]), .span0(span_q[0]), .pat0(pat_q[0]), .qual(qual)
);

// File: tb/sid_span_filter_test.sv
module sid_span_filter_test;
  localparam int NC = 3;
  localparam int SW = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          global_mode = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic          cfg_en = 1'b0;
  logic          cfg_span = 1'b0;
  logic [SW-1:0] cfg_pattern = '0;
  logic          evt_valid = 1'b0;
  logic [SW-1:0] evt_sid = '0;
  logic [NC-1:0] qual;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sid_span_filter #(.NUM_CTR(NC), .SID_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .global_mode(global_mode), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_span(cfg_span),
    .cfg_pattern(cfg_pattern), .evt_valid(evt_valid), .evt_sid(evt_sid),
    .qual(qual)
  );

  task automatic check(input string req, input logic [NC-1:0] exp);
    checks++;
    if (qual !== exp) begin
      errors++;
      $display("FAIL %s qual=%b expected=%b", req, qual, exp);
    end
  endtask

  task automatic wr(input int idx, input logic en, input logic span, input logic [SW-1:0] pat);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_en = en; cfg_span = span; cfg_pattern = pat;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ev(input logic [SW-1:0] sid, input string req, input logic [NC-1:0] exp);
    @(negedge clk);
    evt_valid = 1'b1; evt_sid = sid;
    @(negedge clk);
    evt_valid = 1'b0;
    check(req, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    evt_valid = 1'b1; evt_sid = 16'hBEEF;
    repeat (3) @(negedge clk);
    check("R1 qual in reset", 3'b000);
    evt_valid = 1'b0;
    rst_n = 1'b1;
    ev(16'hBEEF, "R1 filters disabled after reset", 3'b111);
    ev(16'h0000, "R2 disabled filter passes", 3'b111);
  endtask

  task automatic t_idle;
    ev(16'h1234, "R7 strobed result", 3'b111);
    @(negedge clk);
    check("R7 zero after idle edge", 3'b000);
  endtask

  task automatic t_exact;
    wr(0, 1'b1, 1'b0, 16'h1234);
    wr(1, 1'b1, 1'b0, 16'h00FF);
    ev(16'h1234, "R3 exact c0 hit", 3'b101);
    ev(16'h00FF, "R3 exact c1 hit", 3'b110);
    ev(16'h1235, "R3 exact miss by one bit", 3'b100);
  endtask

  task automatic t_span;
    wr(0, 1'b1, 1'b1, 16'h0043);
    wr(1, 1'b1, 1'b1, 16'h0042);
    wr(2, 1'b1, 1'b0, 16'h0047);
    ev(16'h0047, "R4 span top of range", 3'b101);
    ev(16'h0040, "R4 span bottom of range", 3'b001);
    ev(16'h0043, "R4 span narrow window", 3'b011);
    ev(16'h0048, "R4 span just above range", 3'b000);
    ev(16'h0140, "R4 span upper bit differs", 3'b000);
  endtask

  task automatic t_allones;
    wr(1, 1'b1, 1'b1, 16'hFFFF);
    ev(16'h0000, "R5 all ones matches zero", 3'b010);
    ev(16'h1111, "R5 all ones matches any", 3'b010);
  endtask

  task automatic t_global;
    global_mode = 1'b1;
    ev(16'h0045, "R6 global c0 span hit", 3'b111);
    ev(16'h0100, "R6 global others ignored", 3'b000);
    wr(0, 1'b0, 1'b0, 16'h0000);
    ev(16'h0100, "R6 global c0 disabled", 3'b111);
    global_mode = 1'b0;
    ev(16'h0100, "R9 per-counter independent", 3'b011);
  endtask

  task automatic t_writes;
    wr(3, 1'b1, 1'b0, 16'h0001);
    ev(16'h0100, "R8 out-of-range write ignored", 3'b011);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd2; cfg_en = 1'b1; cfg_span = 1'b0; cfg_pattern = 16'h0100;
    evt_valid = 1'b1; evt_sid = 16'h0100;
    @(negedge clk);
    cfg_we = 1'b0; evt_valid = 1'b0;
    check("R8 same-edge event uses old filter", 3'b011);
    ev(16'h0100, "R8 new filter after write", 3'b111);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired qual=%b expected=done", qual);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_exact();
    t_span();
    t_allones();
    t_global();
    t_writes();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule